// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers single-cycle event pulses from a display controller's scan-out and memory-fetch engines into a sticky status word. Software reads that word in two views, unfiltered and filtered by an enable word, over a small register port. It clears serviced events by writing ones to them. The enable word is never written directly: one register address turns bits on and another turns them off, so two software contexts cannot overwrite each other's enables.

The interrupt line is a level. It rises when an enabled event is captured and stays high until software writes the end-of-service address. After that write it stays low until another enabled event arrives, even if older status is still pending, so a pending event never causes repeated interrupts. A separate halt output is raised while both a lost-sync and a fetch-underrun event are pending. The scan-out engine uses it to stop.

Top module: `lcd_irq_unit`

## Requirements
- R1: Events map to fixed status bits: evt_i[0] frame done to bit 0, evt_i[1] lost sync to bit 2, evt_i[2] fetch underrun to bit 5, evt_i[3] palette loaded to bit 6, evt_i[4] buffer-0 end of frame to bit 8, evt_i[5] buffer-1 end of frame to bit 9. A captured bit stays set until it is cleared.
- R2: A read at address 0 returns the raw status. A read at address 1 returns raw status AND enable.
- R3: A write to address 2 sets every enable bit where the data has a one. Zero bits leave their enable unchanged. Reads at address 2 or 3 return the enable word.
- R4: A write to address 3 clears every enable bit where the data has a one. Zero bits leave their enable unchanged.
- R5: A write to address 0 or 1 clears each status bit where the data has a one. Zero bits leave their status bit unchanged.
- R6: An event that arrives in the same cycle as a clearing write to its bit wins, and the bit stays set.
- R7: irq_o rises on the clock edge that captures an event whose enable is set. An event whose enable is clear sets only its status bit. Enabling an already pending bit does not raise irq_o.
- R8: irq_o stays high until a write of any data to address 4. Clearing status does not drop it. After that write, irq_o stays low while old status is pending, until a new enabled event arrives. An enabled event in the same cycle as that write keeps irq_o high.
- R9: fatal_o is high exactly while status bits 2 and 5 are both set.
- R10: Reset clears status, enables, irq_o and read data.
- R11: Bits 1, 3, 4 and 7 read as zero in every view and cannot be enabled.
- R12: Read data appears after the clock edge that samples the read request. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_addr | input | 3 | Register address (0 raw, 1 filtered, 2 enable set, 3 enable clear, 4 end of service) |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Registered read data |
| evt_i | input | 6 | Event pulses, order as in R1 |
| irq_o | output | 1 | Level interrupt |
| fatal_o | output | 1 | Lost sync together with underrun pending |

## Verification
Every result of this block is due one clock edge after its stimulus. Status, enables and irq_o change on the edge that samples an event or a write. Read data comes from a register loaded on the edge that samples the read. fatal_o follows the status register with no extra stage. The bench drives each stimulus at a falling edge and samples all outputs at the next falling edge, which is after exactly one rising edge. Reads are issued in a cycle of their own, so a read always returns the state left by the previous vector.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

  localparam int N_EVT  = 6;
  localparam int STAT_W = 10;
  localparam int ADDR_W = 3;

  // status bit positions; the fatal decode depends on two of them
  localparam int BIT_FRAME  = 0;
  localparam int BIT_SYNC   = 2;
  localparam int BIT_UFLOW  = 5;
  localparam int BIT_PAL    = 6;
  localparam int BIT_EOF0   = 8;
  localparam int BIT_EOF1   = 9;

  localparam int EVT_POS [N_EVT] = '{BIT_FRAME, BIT_SYNC, BIT_UFLOW,
                                     BIT_PAL, BIT_EOF0, BIT_EOF1};

  typedef enum logic [ADDR_W-1:0] {
    A_RAW    = 3'd0,
    A_FILT   = 3'd1,
    A_EN_SET = 3'd2,
    A_EN_CLR = 3'd3,
    A_EOS    = 3'd4
  } reg_addr_e;

  function automatic logic [STAT_W-1:0] valid_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_EVT; i++) m[EVT_POS[i]] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/lcd_irq_evt_map.sv
module lcd_irq_evt_map
  import lcd_irq_pkg::*;
(
  input  logic [N_EVT-1:0]  evt_i,
  output logic [STAT_W-1:0] ev_map
);
  always_comb begin
    ev_map = '0;
    for (int i = 0; i < N_EVT; i++) ev_map[EVT_POS[i]] = evt_i[i];
  end
endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status
  import lcd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_map,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_bits,
  output logic [STAT_W-1:0] raw_q
);
  logic [STAT_W-1:0] raw_d;
  logic              raw_en;

  always_comb begin
    raw_en = clr_wr | (|ev_map);
    raw_d  = raw_q;
    if (clr_wr) raw_d = raw_d & ~clr_bits;
    raw_d  = raw_d | ev_map;   // new event beats the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end
endmodule

// File: rtl/lcd_irq_enable.sv
module lcd_irq_enable
  import lcd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] en_q
);
  localparam logic [STAT_W-1:0] VALID = valid_mask();

  logic [STAT_W-1:0] en_d;
  logic              en_upd;

  always_comb begin
    en_upd = set_wr | clr_wr;
    en_d   = en_q;
    if (set_wr) en_d = en_q | (wdata & VALID);
    if (clr_wr) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end
endmodule

// File: rtl/lcd_irq_line.sv
module lcd_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic new_evt,
  input  logic eos_wr,
  output logic irq_q
);
  logic irq_d;
  logic irq_upd;

  always_comb begin
    irq_upd = new_evt | eos_wr;
    irq_d   = new_evt | (irq_q & ~eos_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_upd) irq_q <= irq_d;
  end
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              irq_o,
  output logic              fatal_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [STAT_W-1:0] ev_map;
  logic [STAT_W-1:0] raw_q;
  logic [STAT_W-1:0] en_q;
  logic [STAT_W-1:0] rd_d;
  logic [STAT_W-1:0] rdata_q;
  logic              wr_acc, rd_acc;
  logic              clr_wr, set_wr, dis_wr, eos_wr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    wr_acc = reg_sel & reg_wr;
    rd_acc = reg_sel & ~reg_wr;
    clr_wr = wr_acc & ((reg_addr == A_RAW) | (reg_addr == A_FILT));
    set_wr = wr_acc & (reg_addr == A_EN_SET);
    dis_wr = wr_acc & (reg_addr == A_EN_CLR);
    eos_wr = wr_acc & (reg_addr == A_EOS);
  end

  lcd_irq_evt_map i_map (.evt_i(evt_i), .ev_map(ev_map));

  lcd_irq_status i_stat (
    .clk(clk), .rst_n(rst_sync_n), .ev_map(ev_map),
    .clr_wr(clr_wr), .clr_bits(reg_wdata), .raw_q(raw_q)
  );

  lcd_irq_enable i_en (
    .clk(clk), .rst_n(rst_sync_n), .set_wr(set_wr),
    .clr_wr(dis_wr), .wdata(reg_wdata), .en_q(en_q)
  );

  lcd_irq_line i_line (
    .clk(clk), .rst_n(rst_sync_n), .new_evt(|(ev_map & en_q)),
    .eos_wr(eos_wr), .irq_q(irq_o)
  );

  always_comb begin
    case (reg_addr)
      A_RAW:            rd_d = raw_q;
      A_FILT:           rd_d = raw_q & en_q;
      A_EN_SET, A_EN_CLR: rd_d = en_q;
      default:          rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_d;
  end

  assign reg_rdata = rdata_q;
  assign fatal_o   = raw_q[BIT_SYNC] & raw_q[BIT_UFLOW];
endmodule

// File: rtl/lcd_irq_unit_chk.sv
module lcd_irq_unit_chk
  import lcd_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] ev_map,
  input logic [STAT_W-1:0] raw_q,
  input logic [STAT_W-1:0] en_q,
  input logic              irq_o
);
  localparam logic [STAT_W-1:0] VALID = valid_mask();

  logic w_clr, w_set, w_dis, w_eos;
  assign w_clr = reg_sel & reg_wr & (reg_addr <= 3'd1);
  assign w_set = reg_sel & reg_wr & (reg_addr == 3'd2);
  assign w_dis = reg_sel & reg_wr & (reg_addr == 3'd3);
  assign w_eos = reg_sel & reg_wr & (reg_addr == 3'd4);

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q | en_q) & ~VALID) == '0);

  a_r6_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_map) |=> ((raw_q & $past(ev_map)) == $past(ev_map)));

  a_r5_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|ev_map) && !w_clr) |=> $stable(raw_q));

  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((en_q & $past(reg_wdata) & VALID) == ($past(reg_wdata) & VALID)));

  a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    w_dis |=> ((en_q & $past(reg_wdata)) == '0));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(ev_map & en_q)));

  a_r8_eos_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (w_eos && !(|(ev_map & en_q))) |=> !irq_o);
endmodule

bind lcd_irq_unit lcd_irq_unit_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ev_map(ev_map),
  .raw_q(raw_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/test_lcd_irq_unit.sv
module test_lcd_irq_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 33;
  localparam logic [1:0] K_IDLE = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

  // {kind, addr, data, evt, expected read, irq, fatal, requirement}
  localparam logic [36:0] VEC [NV] = '{
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h000, 1'b0, 1'b0, 4'd10}, // R10
    {K_RD,   3'd2, 10'h000, 6'h00, 10'h000, 1'b0, 1'b0, 4'd10}, // R10
    {K_IDLE, 3'd0, 10'h000, 6'h01, 10'h000, 1'b0, 1'b0, 4'd7 }, // R7 disabled event
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h001, 1'b0, 1'b0, 4'd1 }, // R1
    {K_RD,   3'd1, 10'h000, 6'h00, 10'h000, 1'b0, 1'b0, 4'd2 }, // R2
    {K_WR,   3'd2, 10'h3FF, 6'h00, 10'h000, 1'b0, 1'b0, 4'd7 }, // R7 enable pending
    {K_RD,   3'd3, 10'h000, 6'h00, 10'h365, 1'b0, 1'b0, 4'd3 }, // R3 R11
    {K_RD,   3'd1, 10'h000, 6'h00, 10'h001, 1'b0, 1'b0, 4'd2 }, // R2
    {K_WR,   3'd3, 10'h005, 6'h00, 10'h000, 1'b0, 1'b0, 4'd4 }, // R4
    {K_RD,   3'd2, 10'h000, 6'h00, 10'h360, 1'b0, 1'b0, 4'd4 }, // R4
    {K_IDLE, 3'd0, 10'h000, 6'h10, 10'h000, 1'b1, 1'b0, 4'd7 }, // R7
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h101, 1'b1, 1'b0, 4'd1 }, // R1
    {K_RD,   3'd1, 10'h000, 6'h00, 10'h100, 1'b1, 1'b0, 4'd2 }, // R2
    {K_WR,   3'd0, 10'h100, 6'h00, 10'h000, 1'b1, 1'b0, 4'd8 }, // R8 clear keeps irq
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h001, 1'b1, 1'b0, 4'd5 }, // R5
    {K_WR,   3'd4, 10'h000, 6'h00, 10'h000, 1'b0, 1'b0, 4'd8 }, // R8
    {K_IDLE, 3'd0, 10'h000, 6'h08, 10'h000, 1'b1, 1'b0, 4'd7 }, // R7
    {K_WR,   3'd4, 10'h155, 6'h00, 10'h000, 1'b0, 1'b0, 4'd8 }, // R8
    {K_IDLE, 3'd0, 10'h000, 6'h00, 10'h000, 1'b0, 1'b0, 4'd8 }, // R8 pending, no repeat
    {K_WR,   3'd0, 10'h040, 6'h08, 10'h000, 1'b1, 1'b0, 4'd6 }, // R6
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h041, 1'b1, 1'b0, 4'd6 }, // R6
    {K_WR,   3'd1, 10'h041, 6'h00, 10'h000, 1'b1, 1'b0, 4'd5 }, // R5
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h000, 1'b1, 1'b0, 4'd5 }, // R5
    {K_WR,   3'd4, 10'h3FF, 6'h20, 10'h000, 1'b1, 1'b0, 4'd8 }, // R8 event beats EOS
    {K_WR,   3'd4, 10'h000, 6'h00, 10'h000, 1'b0, 1'b0, 4'd8 }, // R8
    {K_IDLE, 3'd0, 10'h000, 6'h02, 10'h000, 1'b0, 1'b0, 4'd9 }, // R9
    {K_IDLE, 3'd0, 10'h000, 6'h04, 10'h000, 1'b1, 1'b1, 4'd9 }, // R9
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h224, 1'b1, 1'b1, 4'd1 }, // R1
    {K_WR,   3'd0, 10'h004, 6'h00, 10'h000, 1'b1, 1'b0, 4'd9 }, // R9
    {K_WR,   3'd2, 10'h09A, 6'h00, 10'h000, 1'b1, 1'b0, 4'd11}, // R11
    {K_RD,   3'd2, 10'h000, 6'h00, 10'h360, 1'b1, 1'b0, 4'd11}, // R11
    {K_WR,   3'd0, 10'h000, 6'h00, 10'h000, 1'b1, 1'b0, 4'd5 }, // R5
    {K_RD,   3'd0, 10'h000, 6'h00, 10'h220, 1'b1, 1'b0, 4'd5 }  // R5
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, reg_wr;
  logic [2:0] reg_addr;
  logic [9:0] reg_wdata, reg_rdata;
  logic [5:0] evt_i;
  logic       irq_o, fatal_o;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_irq_unit i_lcd_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_i(evt_i), .irq_o(irq_o), .fatal_o(fatal_o)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    #1;
    chk("R10 irq in reset",   {9'd0, irq_o},   10'h000);
    chk("R10 fatal in reset", {9'd0, fatal_o}, 10'h000);
    chk("R10 rdata in reset", reg_rdata,       10'h000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [9:0] exp, input string req);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    idle_in();
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    do_reset();

    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec %0d", e[3:0], v);
      reg_sel   = (e[36:35] != K_IDLE);
      reg_wr    = (e[36:35] == K_WR);
      reg_addr  = e[34:32];
      reg_wdata = e[31:22];
      evt_i     = e[21:16];
      @(negedge clk);
      idle_in();
      if (e[36:35] == K_RD) chk({tag, " rdata"}, reg_rdata, e[15:6]);
      chk({tag, " irq"},   {9'd0, irq_o},   {9'd0, e[5]});
      chk({tag, " fatal"}, {9'd0, fatal_o}, {9'd0, e[4]});
    end

    // R12: read data holds while no new read is issued
    repeat (2) @(negedge clk);
    chk("R12 rdata hold", reg_rdata, 10'h220);

    // R10: reset in the middle of activity clears every piece of state
    do_reset();
    chk("R10 irq after reset", {9'd0, irq_o}, 10'h000);
    rd(3'd0, 10'h000, "R10 raw after reset");
    rd(3'd2, 10'h000, "R10 enable after reset");

    // R12 and R1: frame-done captured, read issued next cycle returns it
    evt_i = 6'h01;
    @(negedge clk);
    idle_in();
    rd(3'd0, 10'h001, "R12 read latency");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule